// File: doc/BRIEF.md
# Page Load Buffer with Retriggerable Load Window

This block gathers single-byte write events into a page buffer before they reach a slow non-volatile storage array. The first byte opens a page. Each byte after it extends a load window that works like a retriggerable one-shot. When the window runs out with no new byte, the block enters a programming phase. That phase has the same fixed length however many bytes were gathered. On its last cycle the block hands the whole page to the array with a single commit strobe.

While programming runs, a read of the most recently written location returns that byte with bit 7 inverted. Software can poll on that bit to find out when the write has finished. Every other read passes the array's own data through unchanged. The array sits beside the block: it supplies `arr_rdata` for the current `rd_addr` and takes the page on `commit_stb`. The load window and the programming time are both set in clock cycles.

Top module: `page_load_buffer`

## Requirements
- R1: After synchronous reset, `busy`, `programming` and `commit_stb` are low and `rd_data` equals `arr_rdata`.
- R2: A write accepted while idle opens a page and raises `busy` on the following cycle. The page tag is the write address without its low `OFFS_W` bits. A freshly opened page holds exactly one valid lane.
- R3: The low `OFFS_W` address bits (seven by default) choose the byte lane. Lane k occupies `commit_data[8k+7:8k]`. A second write to a lane that is already loaded replaces the earlier byte.
- R4: Each accepted write restarts the load window. `programming` rises exactly `LOAD_CYCLES` clock edges after the edge that took the last write. A write that arrives on the final edge of the window keeps the page loading.
- R5: Programming lasts `PROG_CYCLES` cycles whether one byte or a full page was loaded. `commit_stb` is high only in the last programming cycle. `busy` is low on the next cycle.
- R6: During `commit_stb`, `commit_mask` has bit k set exactly for the lanes written in this page, and `commit_page` carries the page tag.
- R7: A write whose upper address differs from the open page lands on the open page at its own low-bit offset. The page tag does not change.
- R8: Writes that arrive while `programming` is high have no effect on the committed mask, on the committed data, on the polled byte or on the phase timing.
- R9: While `programming` is high, a read of the last written address returns that byte with bit 7 inverted and bits 6..0 unchanged.
- R10: Outside programming, and for any other address during programming, `rd_data` equals `arr_rdata`.
- R11: A write in the first cycle after `busy` falls opens a new page.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Byte write event, one per cycle |
| wr_addr | input | ADDR_W | Byte write address |
| wr_data | input | 8 | Byte write data |
| rd_addr | input | ADDR_W | Read address, also presented to the array |
| arr_rdata | input | 8 | Array data for `rd_addr` |
| rd_data | output | 8 | Read data, with bit 7 inverted for polling |
| busy | output | 1 | Page loading or programming in progress |
| programming | output | 1 | Programming phase active |
| commit_stb | output | 1 | One-cycle page commit toward the array |
| commit_page | output | ADDR_W-OFFS_W | Page tag of the committed page |
| commit_mask | output | 2**OFFS_W | Lanes loaded in the committed page |
| commit_data | output | 8*2**OFFS_W | Lane data, lane k in bits 8k+7..8k |

## Verification
The bench probes the edge of the load window by spacing writes exactly `LOAD_CYCLES-1` idle cycles apart. A timer that expires one cycle early would begin programming and drop the later byte. It loads a page of one byte and a page of 128 bytes, and fails a design whose programming time depends on the byte count. It issues repeated writes to one lane, writes with a foreign page tag, and writes during programming. Each of these shows up at commit as a wrong mask, wrong data, a wrong page tag or a poll value that has shifted. Polling reads to the last address and to a neighbouring address catch bit 7 inverted on the wrong address, or not inverted at all.

// File: rtl/pgbuf_pkg.sv
`timescale 1ns/1ps
package pgbuf_pkg;

    localparam int BYTE_W   = 8;
    localparam int POLL_BIT = 7;

    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_LOAD = 2'd1,
        PH_PROG = 2'd2
    } phase_t;

    typedef struct packed {
        logic              valid;
        logic [BYTE_W-1:0] data;
    } byte_lane_t;

    // Status byte returned while programming: bit 7 flipped, rest intact.
    function automatic logic [BYTE_W-1:0] poll_status(input logic [BYTE_W-1:0] d);
        logic [BYTE_W-1:0] r;
        r = d;
        r[POLL_BIT] = ~d[POLL_BIT];
        return r;
    endfunction

endpackage

// File: rtl/pgbuf_timer.sv
`timescale 1ns/1ps
module pgbuf_timer
    import pgbuf_pkg::*;
#(
    parameter int LOAD_CYCLES = 7500,
    parameter int PROG_CYCLES = 2500000
) (
    input  logic   clk,
    input  logic   rst,
    input  logic   wr_en,
    output phase_t phase,
    output logic   accept,
    output logic   open_pg,
    output logic   commit
);
    localparam int MAX_C = (LOAD_CYCLES > PROG_CYCLES) ? LOAD_CYCLES : PROG_CYCLES;
    localparam int CNT_W = $clog2(MAX_C + 1);
    localparam logic [CNT_W-1:0] LOAD_LAST = CNT_W'(LOAD_CYCLES - 1);
    localparam logic [CNT_W-1:0] PROG_LAST = CNT_W'(PROG_CYCLES - 1);

    phase_t           phase_q;
    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            phase_q <= PH_IDLE;
            cnt_q   <= '0;
        end else begin
            unique case (phase_q)
                PH_IDLE: begin
                    cnt_q <= '0;
                    if (wr_en) phase_q <= PH_LOAD;
                end
                PH_LOAD: begin
                    if (wr_en) begin
                        cnt_q <= '0;
                    end else if (cnt_q == LOAD_LAST) begin
                        phase_q <= PH_PROG;
                        cnt_q   <= '0;
                    end else begin
                        cnt_q <= cnt_q + 1'b1;
                    end
                end
                PH_PROG: begin
                    if (cnt_q == PROG_LAST) begin
                        phase_q <= PH_IDLE;
                        cnt_q   <= '0;
                    end else begin
                        cnt_q <= cnt_q + 1'b1;
                    end
                end
                default: begin
                    phase_q <= PH_IDLE;
                    cnt_q   <= '0;
                end
            endcase
        end
    end

    assign phase   = phase_q;
    assign accept  = wr_en && (phase_q != PH_PROG);
    assign open_pg = wr_en && (phase_q == PH_IDLE);
    assign commit  = (phase_q == PH_PROG) && (cnt_q == PROG_LAST);

    // R4: a byte during loading keeps the page open and restarts the window
    assert_window_restart_R4: assert property (@(posedge clk) disable iff (rst)
        (phase_q == PH_LOAD && wr_en) |=> (phase_q == PH_LOAD && cnt_q == '0));

    // R8: programming cannot be left or re-entered by a write; only commit ends it
    assert_prog_holds_R8: assert property (@(posedge clk) disable iff (rst)
        (phase_q == PH_PROG && !commit) |=> (phase_q == PH_PROG));

    // R5: the commit cycle is the last programming cycle
    assert_commit_exit_R5: assert property (@(posedge clk) disable iff (rst)
        commit |=> (phase_q == PH_IDLE));

endmodule

// File: rtl/pgbuf_store.sv
`timescale 1ns/1ps
module pgbuf_store
    import pgbuf_pkg::*;
#(
    parameter int ADDR_W = 17,
    parameter int OFFS_W = 7,
    localparam int LANES  = 1 << OFFS_W,
    localparam int PAGE_W = ADDR_W - OFFS_W
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    open_pg,
    input  logic                    accept,
    input  logic [ADDR_W-1:0]       wr_addr,
    input  logic [BYTE_W-1:0]       wr_data,
    output logic [PAGE_W-1:0]       page_q,
    output logic [LANES-1:0]        lane_mask,
    output logic [LANES*BYTE_W-1:0] lane_data,
    output logic [ADDR_W-1:0]       last_addr,
    output logic [BYTE_W-1:0]       last_data
);
    logic [OFFS_W-1:0] wr_off;
    logic [OFFS_W-1:0] last_off_q;
    logic [BYTE_W-1:0] last_data_q;

    assign wr_off = wr_addr[OFFS_W-1:0];

    for (genvar i = 0; i < LANES; i++) begin : g_lane
        byte_lane_t lane_q;
        logic       hit;

        assign hit = accept && (wr_off == OFFS_W'(i));

        always_ff @(posedge clk) begin
            if (rst) begin
                lane_q <= '0;
            end else if (hit) begin
                lane_q.valid <= 1'b1;
                lane_q.data  <= wr_data;
            end else if (open_pg) begin
                lane_q.valid <= 1'b0;
            end
        end

        assign lane_mask[i]                  = lane_q.valid;
        assign lane_data[i*BYTE_W +: BYTE_W] = lane_q.data;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            page_q      <= '0;
            last_off_q  <= '0;
            last_data_q <= '0;
        end else begin
            if (open_pg) page_q <= wr_addr[ADDR_W-1:OFFS_W];
            if (accept) begin
                last_off_q  <= wr_off;
                last_data_q <= wr_data;
            end
        end
    end

    assign last_addr = {page_q, last_off_q};
    assign last_data = last_data_q;

    // R2: a newly opened page carries only the byte that opened it
    assert_fresh_page_R2: assert property (@(posedge clk) disable iff (rst)
        open_pg |=> ($countones(lane_mask) == 1));

    // R7: bytes after the first never move the page tag
    assert_page_kept_R7: assert property (@(posedge clk) disable iff (rst)
        (accept && !open_pg) |=> $stable(page_q));

endmodule

// File: rtl/pgbuf_poll.sv
`timescale 1ns/1ps
module pgbuf_poll
    import pgbuf_pkg::*;
#(
    parameter int ADDR_W = 17
) (
    input  logic              programming,
    input  logic [ADDR_W-1:0] rd_addr,
    input  logic [ADDR_W-1:0] last_addr,
    input  logic [BYTE_W-1:0] last_data,
    input  logic [BYTE_W-1:0] arr_rdata,
    output logic [BYTE_W-1:0] rd_data
);
    logic poll_hit;

    assign poll_hit = programming && (rd_addr == last_addr);

    always_comb begin
        rd_data = arr_rdata;
        if (poll_hit) rd_data = poll_status(last_data);
    end

endmodule

// File: rtl/page_load_buffer.sv
`timescale 1ns/1ps
module page_load_buffer
    import pgbuf_pkg::*;
#(
    parameter int ADDR_W      = 17,
    parameter int OFFS_W      = 7,
    parameter int LOAD_CYCLES = 7500,
    parameter int PROG_CYCLES = 2500000,
    localparam int LANES  = 1 << OFFS_W,
    localparam int PAGE_W = ADDR_W - OFFS_W
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    wr_en,
    input  logic [ADDR_W-1:0]       wr_addr,
    input  logic [7:0]              wr_data,
    input  logic [ADDR_W-1:0]       rd_addr,
    input  logic [7:0]              arr_rdata,
    output logic [7:0]              rd_data,
    output logic                    busy,
    output logic                    programming,
    output logic                    commit_stb,
    output logic [PAGE_W-1:0]       commit_page,
    output logic [LANES-1:0]        commit_mask,
    output logic [LANES*8-1:0]      commit_data
);
    phase_t            phase;
    logic              accept;
    logic              open_pg;
    logic [ADDR_W-1:0] last_addr;
    logic [7:0]        last_data;

    pgbuf_timer #(
        .LOAD_CYCLES (LOAD_CYCLES),
        .PROG_CYCLES (PROG_CYCLES)
    ) timer_i (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (wr_en),
        .phase   (phase),
        .accept  (accept),
        .open_pg (open_pg),
        .commit  (commit_stb)
    );

    pgbuf_store #(
        .ADDR_W (ADDR_W),
        .OFFS_W (OFFS_W)
    ) store_i (
        .clk       (clk),
        .rst       (rst),
        .open_pg   (open_pg),
        .accept    (accept),
        .wr_addr   (wr_addr),
        .wr_data   (wr_data),
        .page_q    (commit_page),
        .lane_mask (commit_mask),
        .lane_data (commit_data),
        .last_addr (last_addr),
        .last_data (last_data)
    );

    pgbuf_poll #(
        .ADDR_W (ADDR_W)
    ) poll_i (
        .programming (programming),
        .rd_addr     (rd_addr),
        .last_addr   (last_addr),
        .last_data   (last_data),
        .arr_rdata   (arr_rdata),
        .rd_data     (rd_data)
    );

    assign busy        = (phase != PH_IDLE);
    assign programming = (phase == PH_PROG);

    // R2: a write while idle makes the block busy next cycle
    assert_busy_on_write_R2: assert property (@(posedge clk) disable iff (rst)
        (!busy && wr_en) |=> busy);

    // R6: a busy block always holds at least one loaded lane
    assert_mask_nonempty_R6: assert property (@(posedge clk) disable iff (rst)
        busy |-> (commit_mask != '0));

    // R5: the commit strobe ends the write cycle
    assert_commit_ends_R5: assert property (@(posedge clk) disable iff (rst)
        commit_stb |=> !busy);

    // R10: outside programming the read path is transparent
    assert_passthru_R10: assert property (@(posedge clk) disable iff (rst)
        !programming |-> (rd_data == arr_rdata));

endmodule

// File: tb/page_load_buffer_tb_top.sv
`timescale 1ns/1ps
module page_load_buffer_tb_top;
    localparam int ADDR_W = 17;
    localparam int OFFS_W = 7;
    localparam int LANES  = 1 << OFFS_W;
    localparam int PAGE_W = ADDR_W - OFFS_W;
    localparam int LOADC  = 16;
    localparam int PROGC  = 40;

    localparam int M_SEQ = 1;
    localparam int M_GAP = 2;
    localparam int M_FOR = 4;
    localparam int M_INJ = 8;
    localparam int M_REP = 16;

    logic                clk = 1'b0;
    logic                rst;
    logic                wr_en;
    logic [ADDR_W-1:0]   wr_addr;
    logic [7:0]          wr_data;
    logic [ADDR_W-1:0]   rd_addr;
    logic [7:0]          arr_rdata;
    logic [7:0]          rd_data;
    logic                busy;
    logic                programming;
    logic                commit_stb;
    logic [PAGE_W-1:0]   commit_page;
    logic [LANES-1:0]    commit_mask;
    logic [LANES*8-1:0]  commit_data;

    always #2 clk = ~clk;

    page_load_buffer #(
        .ADDR_W      (ADDR_W),
        .OFFS_W      (OFFS_W),
        .LOAD_CYCLES (LOADC),
        .PROG_CYCLES (PROGC)
    ) dut_i (
        .clk         (clk),
        .rst         (rst),
        .wr_en       (wr_en),
        .wr_addr     (wr_addr),
        .wr_data     (wr_data),
        .rd_addr     (rd_addr),
        .arr_rdata   (arr_rdata),
        .rd_data     (rd_data),
        .busy        (busy),
        .programming (programming),
        .commit_stb  (commit_stb),
        .commit_page (commit_page),
        .commit_mask (commit_mask),
        .commit_data (commit_data)
    );

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    logic [7:0]        mem [int];
    logic [LANES-1:0]  exp_mask;
    logic [7:0]        exp_data [LANES];
    logic [ADDR_W-1:0] exp_last;
    logic [7:0]        exp_last_d;

    function automatic logic [7:0] arr_of(input logic [ADDR_W-1:0] a);
        if (mem.exists(int'(a))) return mem[int'(a)];
        return 8'hFF;
    endfunction

    function automatic logic [7:0] poll_exp(input logic [7:0] d);
        return {~d[7], d[6:0]};
    endfunction

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic read_chk(input logic [ADDR_W-1:0] a, input logic [7:0] exp,
                            input string req, input string what);
        rd_addr   = a;
        arr_rdata = arr_of(a);
        #1;
        chk(rd_data == exp, req, what, 64'(rd_data), 64'(exp));
    endtask

    task automatic do_write(input logic [ADDR_W-1:0] a, input logic [7:0] d);
        wr_en   = 1'b1;
        wr_addr = a;
        wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic run_page(input int page, input int n, input int mode);
        exp_mask = '0;
        chk(!busy, "R11", "idle before page", 64'(busy), 64'(0));
        for (int j = 0; j < n; j++) begin
            int                off;
            int                pg;
            logic [7:0]        d;
            if ((mode & M_SEQ) != 0)      off = j % LANES;
            else if ((mode & M_REP) != 0) off = 5;
            else                          off = int'($urandom % LANES);
            pg = (((mode & M_FOR) != 0) && j > 0 && (j % 3 == 0)) ? (page ^ 1) : page;
            d  = 8'($urandom);
            if (j > 0) begin
                int gap;
                gap = ((mode & M_GAP) != 0) ? (LOADC - 1) : int'($urandom % LOADC);
                for (int g = 0; g < gap; g++) begin
                    @(negedge clk);
                    chk(!programming, "R4", "window still open", 64'(programming), 64'(0));
                    if (g == 0)
                        read_chk(exp_last, arr_of(exp_last), "R10", "read while loading");
                end
            end
            do_write({PAGE_W'(pg), OFFS_W'(off)}, d);
            exp_mask[off] = 1'b1;
            exp_data[off] = d;
            exp_last      = {PAGE_W'(page), OFFS_W'(off)};
            exp_last_d    = d;
            if (j == 0) chk(busy, "R2", "busy after first byte", 64'(busy), 64'(1));
        end
        repeat (LOADC - 1) begin
            @(negedge clk);
            chk(!programming, "R4", "no early programming", 64'(programming), 64'(0));
        end
        @(negedge clk);
        chk(programming && busy, "R4", "programming at window expiry", 64'(programming), 64'(1));
        for (int i = 1; i < PROGC; i++) begin
            if (((mode & M_INJ) != 0) && (i % 4 == 1) && (i < PROGC - 1)) begin
                wr_en   = 1'b1;
                wr_addr = ((i % 8) == 1) ? exp_last : ADDR_W'($urandom);
                wr_data = ~exp_last_d;
            end else begin
                wr_en = 1'b0;
            end
            @(negedge clk);
            wr_en = 1'b0;
            chk(commit_stb == (i == PROGC - 1), "R5", "commit strobe timing",
                64'(commit_stb), 64'(i == PROGC - 1));
            if (i == 2 || i == PROGC - 2)
                read_chk(exp_last, poll_exp(exp_last_d), "R9", "polled last byte");
            if (i == 3)
                read_chk(exp_last ^ ADDR_W'(1), arr_of(exp_last ^ ADDR_W'(1)),
                         "R10", "other address during programming");
            if (i == PROGC - 1) begin
                bit okd;
                okd = 1'b1;
                for (int k = 0; k < LANES; k++)
                    if (exp_mask[k] && commit_data[k*8 +: 8] != exp_data[k]) okd = 1'b0;
                chk(commit_page == PAGE_W'(page), "R7", "committed page tag",
                    64'(commit_page), 64'(page));
                chk(commit_mask == exp_mask, "R6", "committed mask (popcount shown)",
                    64'($countones(commit_mask)), 64'($countones(exp_mask)));
                chk(okd, "R3", "committed lane data", 64'(okd), 64'(1));
                if ((mode & M_INJ) != 0)
                    chk(okd && commit_mask == exp_mask, "R8", "writes while programming ignored",
                        64'(okd), 64'(1));
                for (int k = 0; k < LANES; k++)
                    if (exp_mask[k]) mem[int'({PAGE_W'(page), OFFS_W'(k)})] = exp_data[k];
            end
        end
        @(negedge clk);
        chk(!busy && !commit_stb && !programming, "R5", "idle after commit",
            64'(busy), 64'(0));
        read_chk(exp_last, arr_of(exp_last), "R10", "true data after commit");
    endtask

    initial begin
        #(4 * 150000);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5eed_1234));
        rst       = 1'b1;
        wr_en     = 1'b0;
        wr_addr   = '0;
        wr_data   = '0;
        rd_addr   = '0;
        arr_rdata = 8'h3C;
        repeat (3) @(negedge clk);
        chk(!busy && !programming && !commit_stb, "R1", "reset outputs", 64'(busy), 64'(0));
        #1;
        chk(rd_data == arr_rdata, "R1", "reset read path", 64'(rd_data), 64'(arr_rdata));
        rst = 1'b0;
        @(negedge clk);

        run_page(3, 1, 0);
        run_page(4, LANES, M_SEQ);
        run_page(5, 6, M_REP);
        run_page(6, 9, M_FOR);
        run_page(7, 5, M_GAP);
        run_page(8, 7, M_INJ);
        run_page(9, 4, M_FOR | M_INJ | M_GAP);
        for (int r = 0; r < 12; r++)
            run_page(int'($urandom % 12), 1 + int'($urandom % 24), int'($urandom % 32));

        done = 1'b1;
        $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule